// File: doc/BRIEF.md
# External interrupt pin controller

This block gathers up to eight asynchronous interrupt pins into a small register-mapped controller. Each pin passes through a two-flop synchronizer. It is then qualified by its own sense mode: falling edge, rising edge, low level, high level, or both edges. A detection latches a per-pin pending bit. A pin raises its request only when the pin is unmasked, its priority field is nonzero, and its pending bit is set. All per-pin requests are ORed onto one summary request.

Software uses a single-cycle strobe port to reach five 32-bit registers: sense configuration, priority, pending source, mask-set and mask-clear. Pin 0 always sits in the most significant bits of each register. The sense and priority registers read back in full, so software can change one field by read-modify-write. Pending bits are cleared by writing zeros. Masks change through the write-one set and clear registers, which makes each mask update atomic.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset, the sense, priority and source registers all read 0. Every pin is masked, so a pending bit set before any unmask drives no request.
- R2: Address 0 (sense) holds one SENSE_W-bit field per pin. Address 1 (priority) holds one 4-bit field per pin. The field for pin n starts at bit 32-(n+1)*W. Both registers read back exactly what was last written to the implemented fields.
- R3: Address 3 (mask-set) and address 4 (mask-clear) always read 0.
- R4: Sense code 0 latches on a falling edge, code 1 on a rising edge, and code 4 on either edge. A pin change driven between clock edges shows in the source register (address 2, pin n at bit 31-n) after the third rising clock edge, and not before it.
- R5: Sense code 2 (low) and code 3 (high) set the pending bit on every cycle the synchronized pin is at the active level. A clearing write in that state leaves the bit set.
- R6: Sense codes 5 to 15 never set a pending bit, whatever the pin does.
- R7: A write to the source register clears each pending bit whose data bit is 0 and keeps each bit whose data bit is 1. A detection in the same cycle wins over the clear.
- R8: Writing 1 at bit 31-n of mask-set masks pin n. Writing 1 at that bit of mask-clear unmasks it. Zero data bits change nothing.
- R9: irq_o[n] is high exactly when pin n is pending, unmasked, and its priority field is nonzero. irq_any_o is the OR of all irq_o bits.
- R10: A pending bit latches even while the pin is masked or has zero priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | NUM_PINS | Asynchronous external interrupt pins |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read, while acc_en is high |
| acc_addr | input | 3 | Register select (0 sense, 1 priority, 2 source, 3 mask-set, 4 mask-clear) |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for acc_addr, combinational |
| irq_o | output | NUM_PINS | Per-pin interrupt requests |
| irq_any_o | output | 1 | OR of all per-pin requests |

## Verification
The assertions take it that at most one register is written per cycle. They also take it that the access strobe is a clean synchronous signal, while the pins may change at any time. The stimulus changes pins and bus inputs only at the falling clock edge and holds each value for at least a full cycle, so the synchronizer sees every pulse. The pins stay low through reset, so the reset value of the synchronizer cannot look like an edge. Random phases draw from the five defined addresses and from the full range of sense codes, invalid ones included.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 3;
    localparam int CODE_W = 4;

    localparam logic [ADDR_W-1:0] A_SENSE  = 3'd0;
    localparam logic [ADDR_W-1:0] A_PRIO   = 3'd1;
    localparam logic [ADDR_W-1:0] A_SOURCE = 3'd2;
    localparam logic [ADDR_W-1:0] A_MSET   = 3'd3;
    localparam logic [ADDR_W-1:0] A_MCLR   = 3'd4;

    typedef enum logic [CODE_W-1:0] {
        SNS_FALL = 4'd0,
        SNS_RISE = 4'd1,
        SNS_LOW  = 4'd2,
        SNS_HIGH = 4'd3,
        SNS_BOTH = 4'd4
    } sense_e;

endpackage

// File: rtl/extirq_pin_detect.sv
module extirq_pin_detect
    import extirq_pkg::*;
#(
    parameter int SENSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_i,
    input  logic [SENSE_W-1:0] sense_i,
    output logic               hit_o
);

    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } det_t;

    det_t             det_d, det_q;
    logic [CODE_W-1:0] code;

    always_comb begin
        det_d      = det_q;
        det_d.meta = pin_i;
        det_d.sync = det_q.meta;
        det_d.prev = det_q.sync;

        code                = '0;
        code[SENSE_W-1:0]   = sense_i;

        case (code)
            SNS_FALL: hit_o = det_q.prev & ~det_q.sync;
            SNS_RISE: hit_o = det_q.sync & ~det_q.prev;
            SNS_LOW:  hit_o = ~det_q.sync;
            SNS_HIGH: hit_o = det_q.sync;
            SNS_BOTH: hit_o = det_q.sync ^ det_q.prev;
            default:  hit_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

    // R6: undefined sense codes stay silent
    p_bad_code_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (code > 4'd4) |-> !hit_o);

endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
    import extirq_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int SENSE_W  = 4,
    parameter int PRIO_W   = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              acc_en,
    input  logic                              acc_wr,
    input  logic [ADDR_W-1:0]                 acc_addr,
    input  logic [REG_W-1:0]                  acc_wdata,
    input  logic [NUM_PINS-1:0]               hit_i,
    output logic [NUM_PINS-1:0][SENSE_W-1:0]  sense_o,
    output logic [NUM_PINS-1:0]               prio_on_o,
    output logic [NUM_PINS-1:0]               pend_o,
    output logic [NUM_PINS-1:0]               mask_o,
    output logic [REG_W-1:0]                  rdata_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0][SENSE_W-1:0] sense;
        logic [NUM_PINS-1:0][PRIO_W-1:0]  prio;
        logic [NUM_PINS-1:0]              pend;
        logic [NUM_PINS-1:0]              mask;
    } regs_t;

    regs_t               r_d, r_q;
    logic                wr_sense, wr_prio, wr_src, wr_mset, wr_mclr;
    logic [NUM_PINS-1:0] pin_bits;

    always_comb begin
        wr_sense = acc_en & acc_wr & (acc_addr == A_SENSE);
        wr_prio  = acc_en & acc_wr & (acc_addr == A_PRIO);
        wr_src   = acc_en & acc_wr & (acc_addr == A_SOURCE);
        wr_mset  = acc_en & acc_wr & (acc_addr == A_MSET);
        wr_mclr  = acc_en & acc_wr & (acc_addr == A_MCLR);

        r_d     = r_q;
        rdata_o = '0;
        for (int n = 0; n < NUM_PINS; n++) begin
            pin_bits[n] = acc_wdata[REG_W-1-n];

            if (wr_sense) r_d.sense[n] = acc_wdata[REG_W-(n+1)*SENSE_W +: SENSE_W];
            if (wr_prio)  r_d.prio[n]  = acc_wdata[REG_W-(n+1)*PRIO_W +: PRIO_W];
            if (wr_src)   r_d.pend[n]  = r_q.pend[n] & pin_bits[n];
            if (wr_mset && pin_bits[n]) r_d.mask[n] = 1'b1;
            if (wr_mclr && pin_bits[n]) r_d.mask[n] = 1'b0;
            r_d.pend[n] = r_d.pend[n] | hit_i[n];

            case (acc_addr)
                A_SENSE:  rdata_o[REG_W-(n+1)*SENSE_W +: SENSE_W] = r_q.sense[n];
                A_PRIO:   rdata_o[REG_W-(n+1)*PRIO_W +: PRIO_W]   = r_q.prio[n];
                A_SOURCE: rdata_o[REG_W-1-n]                      = r_q.pend[n];
                default:  ;
            endcase

            prio_on_o[n] = |r_q.prio[n];
        end
        sense_o = r_q.sense;
        pend_o  = r_q.pend;
        mask_o  = r_q.mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.sense <= '0;
            r_q.prio  <= '0;
            r_q.pend  <= '0;
            r_q.mask  <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    // R7: after a source write only kept or freshly hit bits remain
    p_src_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_src |=> ((r_q.pend & ~($past(pin_bits) | $past(hit_i))) == '0));

    // R10: a detection always latches, masked or not
    p_hit_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_i) |=> ((r_q.pend & $past(hit_i)) == $past(hit_i)));

    // R8: write-one set and clear of masks
    p_mask_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mset |=> ((r_q.mask & $past(pin_bits)) == $past(pin_bits)));

    p_mask_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mclr |=> ((r_q.mask & $past(pin_bits)) == '0));

    p_mask_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_mset || wr_mclr) |=> $stable(r_q.mask));

    // R2: configuration only moves on its own write
    p_cfg_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sense |=> $stable(r_q.sense));

endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
    import extirq_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int SENSE_W  = 4,
    parameter int PRIO_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                acc_en,
    input  logic                acc_wr,
    input  logic [2:0]          acc_addr,
    input  logic [31:0]         acc_wdata,
    output logic [31:0]         acc_rdata,
    output logic [NUM_PINS-1:0] irq_o,
    output logic                irq_any_o
);

    logic [NUM_PINS-1:0][SENSE_W-1:0] sense;
    logic [NUM_PINS-1:0]              hit, prio_on, pend, mask;

    extirq_regs #(
        .NUM_PINS (NUM_PINS),
        .SENSE_W  (SENSE_W),
        .PRIO_W   (PRIO_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .acc_wr    (acc_wr),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .hit_i     (hit),
        .sense_o   (sense),
        .prio_on_o (prio_on),
        .pend_o    (pend),
        .mask_o    (mask),
        .rdata_o   (acc_rdata)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        extirq_pin_detect #(
            .SENSE_W (SENSE_W)
        ) i_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pin_i[g]),
            .sense_i (sense[g]),
            .hit_o   (hit[g])
        );
    end

    always_comb begin
        irq_o     = pend & ~mask & prio_on;
        irq_any_o = |irq_o;
    end

    // R9: a request is never raised for a pin that is masked
    p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & mask) == '0));

endmodule

// File: tb/test_extirq_ctrl.sv
module test_extirq_ctrl;

    localparam int NP = 8;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] pin;
    logic          acc_en, acc_wr;
    logic [2:0]    acc_addr;
    logic [31:0]   acc_wdata;
    logic [31:0]   acc_rdata;
    logic [NP-1:0] irq;
    logic          irq_any;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    extirq_ctrl #(.NUM_PINS(NP), .SENSE_W(SW), .PRIO_W(4)) i_extirq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin),
        .acc_en    (acc_en),
        .acc_wr    (acc_wr),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .irq_o     (irq),
        .irq_any_o (irq_any)
    );

    // behavioural reference model
    int            m_sense[NP];
    int            m_prio[NP];
    bit            m_pend[NP];
    bit            m_mask[NP];
    logic [NP-1:0] hist[$];
    bit            m_hit[NP];
    logic [NP-1:0] cur, prv;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NP; n++) begin
                m_sense[n] = 0; m_prio[n] = 0; m_pend[n] = 0; m_mask[n] = 1;
            end
            hist.delete();
            repeat (3) hist.push_back('0);
        end else begin
            cur = hist[1];
            prv = hist[2];
            for (int n = 0; n < NP; n++) begin
                case (m_sense[n])
                    0: m_hit[n] = prv[n] && !cur[n];
                    1: m_hit[n] = cur[n] && !prv[n];
                    2: m_hit[n] = !cur[n];
                    3: m_hit[n] = cur[n];
                    4: m_hit[n] = cur[n] != prv[n];
                    default: m_hit[n] = 0;
                endcase
            end
            if (acc_en && acc_wr) begin
                for (int n = 0; n < NP; n++) begin
                    case (acc_addr)
                        3'd0: m_sense[n] = int'((acc_wdata >> (32 - (n + 1) * SW)) & ((1 << SW) - 1));
                        3'd1: m_prio[n]  = int'((acc_wdata >> (32 - (n + 1) * 4)) & 15);
                        3'd2: if (!acc_wdata[31-n]) m_pend[n] = 0;
                        3'd3: if (acc_wdata[31-n]) m_mask[n] = 1;
                        3'd4: if (acc_wdata[31-n]) m_mask[n] = 0;
                        default: ;
                    endcase
                end
            end
            for (int n = 0; n < NP; n++) if (m_hit[n]) m_pend[n] = 1;
            hist.push_front(pin);
            void'(hist.pop_back());
        end
    end

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        logic [31:0] r = '0;
        for (int n = 0; n < NP; n++) begin
            case (a)
                3'd0: r = r | (32'(m_sense[n]) << (32 - (n + 1) * SW));
                3'd1: r = r | (32'(m_prio[n]) << (32 - (n + 1) * 4));
                3'd2: r[31-n] = m_pend[n];
                default: ;
            endcase
        end
        return r;
    endfunction

    function automatic logic [NP-1:0] exp_irq();
        logic [NP-1:0] r;
        for (int n = 0; n < NP; n++) r[n] = m_pend[n] && !m_mask[n] && (m_prio[n] != 0);
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // one cycle: sample away from the edge, compare against the model
    task automatic tick();
        logic [NP-1:0] e;
        @(negedge clk);
        e = exp_irq();
        chk("R9 irq", 32'(irq), 32'(e));
        chk("R9 irq_any", 32'(irq_any), 32'(|e));
        chk("R2 readback", acc_rdata, exp_rd(acc_addr));
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
        tick();
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input string req, input logic [31:0] exp);
        acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
        tick();
        chk(req, acc_rdata, exp);
        acc_en = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; pin = '0; acc_en = 1'b0; acc_wr = 1'b0;
        acc_addr = '0; acc_wdata = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1, R3: reset state
        rd(3'd0, "R1 sense reset", 32'h0);
        rd(3'd1, "R1 prio reset", 32'h0);
        rd(3'd2, "R1 source reset", 32'h0);
        chk("R1 no request", 32'(irq), 32'h0);
        rd(3'd3, "R3 mask-set reads 0", 32'h0);
        rd(3'd4, "R3 mask-clear reads 0", 32'h0);

        // R2: pins 0..7 = rise, fall, low, high, both, 7, 15, rise
        wr(3'd0, 32'h102347F1);
        rd(3'd0, "R2 sense readback", 32'h102347F1);
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, "R2 prio readback", 32'hFFFF_FFFF);

        // R10 + R1: low-level pin 2 latches while still masked
        rd(3'd2, "R10 latch while masked", 32'h2000_0000);
        chk("R1 masked after reset", 32'(irq), 32'h0);
        wr(3'd4, 32'hFF00_0000);
        chk("R9 pin2 request", 32'(irq), 32'h04);

        // R7: pin 2 to high level, then clear all
        wr(3'd0, 32'h103347F1);
        wr(3'd2, 32'h0);
        rd(3'd2, "R7 clear all", 32'h0);

        // R4: rising edge latency on pin 0
        acc_addr = 3'd2;
        pin[0] = 1'b1;
        tick(); tick();
        chk("R4 not before third edge", acc_rdata, 32'h0);
        tick();
        chk("R4 rising at third edge", acc_rdata, 32'h8000_0000);

        // R4: falling mode on pin 1
        pin[1] = 1'b1;
        repeat (4) tick();
        chk("R4 falling ignores rise", acc_rdata, 32'h8000_0000);
        pin[1] = 1'b0;
        repeat (3) tick();
        chk("R4 falling edge", acc_rdata, 32'hC000_0000);

        // R4: both-edge mode on pin 4
        wr(3'd2, 32'h0);
        pin[4] = 1'b1;
        acc_addr = 3'd2;
        repeat (3) tick();
        chk("R4 both rise", acc_rdata, 32'h0800_0000);
        wr(3'd2, 32'h0);
        pin[4] = 1'b0;
        acc_addr = 3'd2;
        repeat (3) tick();
        chk("R4 both fall", acc_rdata, 32'h0800_0000);

        // R6: invalid codes on pins 5 and 6
        wr(3'd2, 32'h0);
        for (int k = 0; k < 10; k++) begin
            pin[5] = ~pin[5]; pin[6] = ~pin[6];
            tick(); tick();
        end
        pin[5] = 1'b0; pin[6] = 1'b0;
        repeat (4) tick();
        rd(3'd2, "R6 invalid codes quiet", 32'h0);

        // R7: partial clear
        pin[0] = 1'b0;
        repeat (4) tick();
        wr(3'd2, 32'h0);
        pin[0] = 1'b1; pin[7] = 1'b1;
        repeat (4) tick();
        rd(3'd2, "R4 two rising pins", 32'h8100_0000);
        wr(3'd2, 32'h7FFF_FFFF);
        rd(3'd2, "R7 partial clear", 32'h0100_0000);

        // R8: masks
        chk("R9 pin7 request", 32'(irq), 32'h80);
        wr(3'd3, 32'h0100_0000);
        chk("R8 mask-set", 32'(irq), 32'h0);
        chk("R8 mask-set any", 32'(irq_any), 32'h0);
        wr(3'd3, 32'h0);
        wr(3'd4, 32'h0);
        chk("R8 zero writes no effect", 32'(irq), 32'h0);
        wr(3'd4, 32'h0100_0000);
        chk("R8 mask-clear", 32'(irq), 32'h80);

        // R9: zero priority blocks
        wr(3'd1, 32'hFFFF_FFF0);
        chk("R9 zero prio blocks", 32'(irq), 32'h0);
        rd(3'd1, "R2 prio field readback", 32'hFFFF_FFF0);
        wr(3'd1, 32'hFFFF_FFFF);
        chk("R9 prio restored", 32'(irq), 32'h80);

        // R5: high level persists through a clear
        pin[3] = 1'b1;
        acc_addr = 3'd2;
        repeat (3) tick();
        chk("R5 high level set", acc_rdata, 32'h1100_0000);
        wr(3'd2, 32'h0);
        rd(3'd2, "R5 clear ineffective", 32'h1000_0000);
        pin[3] = 1'b0;
        repeat (3) tick();
        wr(3'd2, 32'h0);
        rd(3'd2, "R5 clear after level gone", 32'h0);

        // random phase, model compared every cycle
        for (int k = 0; k < 600; k++) begin
            pin      = NP'($urandom);
            acc_addr = 3'($urandom_range(0, 4));
            acc_en   = ($urandom_range(0, 3) == 0);
            acc_wr   = acc_en && ($urandom_range(0, 1) == 0);
            acc_wdata = $urandom;
            tick();
        end
        acc_en = 1'b0; acc_wr = 1'b0;
        tick();

        summary();
        $finish;
    end

endmodule